// File: doc/BRIEF.md
# Quadrant-Offset Phase Estimator

This block turns one complex frequency-domain sample, given as a signed real part and a signed imaginary part, into an unsigned fixed-point phase word. A typical use is the phase of an FFT bin during time-delay estimation. Both parts are first reduced to magnitudes. An iterative vectoring rotator then finds the first-quadrant arctangent of the ratio of the two magnitudes, one micro-rotation per clock. A constant chosen only from the two sign bits is added to that angle.

The added constant is a fixed quarter-turn step, not a mirror of the angle. The output is therefore not a true four-quadrant arctangent. For example, a sample with negative real part and positive imaginary part reports a quarter turn plus the arctangent of the magnitude ratio. The block accepts one sample at a time. It signals with a busy flag while it works, and it gives the result together with a one-cycle valid pulse.

Top module: `phase_quad_est`

## Requirements
- R1: After reset, `out_valid` and `busy` are low and `out_phase` is 0x0000.
- R2: A sample is taken at a rising edge where `in_valid` is high and `busy` is low. From the next cycle on, `busy` stays high up to and including the cycle in which `out_valid` is high. It is low in the following cycle.
- R3: `out_valid` is high for exactly one cycle. That cycle is the 16th cycle after the cycle in which the sample was presented, counting the presenting cycle as cycle 0.
- R4: The phase format is unsigned 16-bit, with 65536 codes per full turn, so a quarter turn is 0x4000. When `in_x` ≥ 0 and `in_y` ≥ 0, the result is atan(|y|/|x|) in this format, within 8 codes. This holds for magnitudes of at least 1000.
- R5: When `in_x` < 0 and `in_y` ≥ 0, the result is atan(|y|/|x|) + 0x4000, within 8 codes.
- R6: When `in_x` < 0 and `in_y` < 0, the result is atan(|y|/|x|) + 0x8000, within 8 codes.
- R7: When `in_x` ≥ 0 and `in_y` < 0, the result is atan(|y|/|x|) + 0xC000, within 8 codes.
- R8: The sum of angle and offset wraps modulo 65536. For example, x = 0 with a negative y gives a result close to 0x0000.
- R9: An input of −32768 is treated as a magnitude of 32767, not as a wrapped negative value. For example, (−32768, −32768) gives about 0xA000.
- R10: For x = 0 and y = 0, the result is exactly 0x0000.
- R11: `in_valid` pulses while `busy` is high are ignored. They produce no extra `out_valid`, and they do not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Sample strobe, taken only while idle |
| in_x | input | 16 | Real part, two's complement |
| in_y | input | 16 | Imaginary part, two's complement |
| busy | output | 1 | High while a sample is in flight |
| out_valid | output | 1 | One-cycle result strobe |
| out_phase | output | 16 | Phase, full scale is one turn |

## Verification
The hardest conditions to reach from the ports are the two ends of the offset adder and the saturating absolute value. The offset adder is reached through a vector on the negative imaginary axis, where the three-quarter-turn offset plus a quarter-turn angle lands on zero. The sign-select boundaries are reached through vectors on each axis. The saturating absolute value is reached by driving −32768 on either part alone and on both parts together. These results are compared modulo one turn. A second hard condition is a stream of strobes arriving while a sample is in flight. The stimulus holds `in_valid` high on every cycle in which `busy` is seen high, including the cycle of the result strobe. The scoreboard then checks that exactly one result comes back and that it carries the first sample's phase.

// File: rtl/phq_pkg.sv
package phq_pkg;

  // Sign-derived region index; the phase offset is index * quarter turn.
  typedef enum logic [1:0] {
    REG_XP_YP = 2'd0,
    REG_XN_YP = 2'd1,
    REG_XN_YN = 2'd2,
    REG_XP_YN = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROT   = 2'd1,
    ST_SUM   = 2'd2,
    ST_EMIT  = 2'd3
  } fsm_e;

  // atan(2^-i) expressed in units of 2^-32 turn.
  function automatic logic [31:0] atan_turn32(input int i);
    case (i)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      default: return 32'd683565276 >> i;
    endcase
  endfunction

endpackage

// File: rtl/phq_front.sv
module phq_front #(
  parameter int IN_W = 16
) (
  input  logic signed [IN_W-1:0] x_in,
  input  logic signed [IN_W-1:0] y_in,
  output logic [IN_W-1:0]        mag_x,
  output logic [IN_W-1:0]        mag_y,
  output phq_pkg::region_e       region,
  output logic                   both_zero
);
  import phq_pkg::*;

  localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [IN_W-1:0] MOST_POS = {1'b0, {(IN_W-1){1'b1}}};

  function automatic logic [IN_W-1:0] abs_sat(input logic signed [IN_W-1:0] v);
    if (!v[IN_W-1])               return unsigned'(v);
    else if (unsigned'(v) == MOST_NEG) return MOST_POS;
    else                          return unsigned'(-v);
  endfunction

  always_comb begin
    mag_x     = abs_sat(x_in);
    mag_y     = abs_sat(y_in);
    both_zero = (x_in == '0) && (y_in == '0);
    case ({x_in[IN_W-1], y_in[IN_W-1]})
      2'b00:   region = REG_XP_YP;
      2'b10:   region = REG_XN_YP;
      2'b11:   region = REG_XN_YN;
      default: region = REG_XP_YN;
    endcase
  end

  // R9: a magnitude never carries the sign bit, even for the most negative code
  always_comb begin
    if (!$isunknown({x_in, y_in})) begin
      assert_mag_saturated_R9: assert (!mag_x[IN_W-1] && !mag_y[IN_W-1])
        else $error("magnitude overflowed into sign bit");
    end
  end

endmodule

// File: rtl/phq_ctrl.sv
module phq_ctrl #(
  parameter int ITER = 14,
  parameter int IW   = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          accept,
  output logic          step,
  output logic [IW-1:0] idx,
  output logic          finish,
  output logic          busy,
  output logic          out_valid
);
  import phq_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(ITER - 1);

  fsm_e          state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    accept  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          accept  = 1'b1;
          state_d = ST_ROT;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_ROT: begin
        idx_en = 1'b1;
        idx_d  = idx_q + IW'(1);
        if (idx_q == LAST_IDX) state_d = ST_SUM;
      end
      ST_SUM:  state_d = ST_EMIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign step      = (state_q == ST_ROT);
  assign idx       = idx_q;
  assign finish    = (state_q == ST_SUM);
  assign busy      = (state_q != ST_IDLE);
  assign out_valid = (state_q == ST_EMIT);

  // R3: result strobe lasts one cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R2: accepting a sample raises busy on the next cycle
  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);
  // R2: busy still high while the result is presented
  assert_busy_with_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

endmodule

// File: rtl/phq_cordic.sv
module phq_cordic #(
  parameter int IN_W  = 16,
  parameter int PH_W  = 16,
  parameter int ITER  = 14,
  parameter int GUARD = 4,
  parameter int ZG    = 2,
  parameter int IW    = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [IW-1:0]   idx,
  input  logic [IN_W-1:0] mag_x,
  input  logic [IN_W-1:0] mag_y,
  output logic [PH_W-1:0] angle
);
  import phq_pkg::*;

  localparam int DW    = IN_W + GUARD + 2;   // room for gain of sqrt(2)*1.65
  localparam int ZW    = PH_W + ZG + 1;
  localparam int TSHFT = 32 - PH_W - ZG;
  localparam logic signed [ZW-1:0] HALF = ZW'(1) <<< (ZG - 1);

  logic signed [ZW-1:0] ang_tab [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_tab
    localparam logic [32:0] RAW = {1'b0, atan_turn32(g)} + (33'd1 << (TSHFT - 1));
    assign ang_tab[g] = ZW'(RAW >> TSHFT);
  end

  logic signed [DW-1:0] x_q, y_q, x_d, y_d, xs, ys;
  logic signed [ZW-1:0] z_q, z_d, z_rnd;
  logic                 en;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    z_d = z_q;
    xs  = x_q >>> idx;
    ys  = y_q >>> idx;
    en  = load || step;
    if (load) begin
      x_d = signed'({{(DW-IN_W){1'b0}}, mag_x}) <<< GUARD;
      y_d = signed'({{(DW-IN_W){1'b0}}, mag_y}) <<< GUARD;
      z_d = '0;
    end else if (step) begin
      if (!y_q[DW-1]) begin
        x_d = x_q + ys;
        y_d = y_q - xs;
        z_d = z_q + ang_tab[idx];
      end else begin
        x_d = x_q - ys;
        y_d = y_q + xs;
        z_d = z_q - ang_tab[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (en) begin
      x_q <= x_d;
      y_q <= y_d;
      z_q <= z_d;
    end
  end

  assign z_rnd = z_q + HALF;
  assign angle = PH_W'(z_rnd >>> ZG);

  // R9: the rotating vector's real part stays non-negative (saturated magnitudes)
  assert_core_x_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !x_q[DW-1]);

endmodule

// File: rtl/phase_quad_est.sv
module phase_quad_est #(
  parameter int IN_W = 16,
  parameter int PH_W = 16,
  parameter int ITER = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_x,
  input  logic [IN_W-1:0] in_y,
  output logic            busy,
  output logic            out_valid,
  output logic [PH_W-1:0] out_phase
);
  import phq_pkg::*;

  localparam int IW    = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int LAT   = ITER + 2;
  localparam int LCW   = $clog2(LAT + 1);

  logic [IN_W-1:0] mag_x, mag_y;
  region_e         region, region_q;
  logic            both_zero, zero_q;
  logic            accept, step, finish;
  logic [IW-1:0]   idx;
  logic [PH_W-1:0] core_angle;
  logic [PH_W-1:0] phase_q, phase_d;

  phq_front #(.IN_W(IN_W)) u_front (
    .x_in      (signed'(in_x)),
    .y_in      (signed'(in_y)),
    .mag_x     (mag_x),
    .mag_y     (mag_y),
    .region    (region),
    .both_zero (both_zero)
  );

  phq_ctrl #(.ITER(ITER), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .step      (step),
    .idx       (idx),
    .finish    (finish),
    .busy      (busy),
    .out_valid (out_valid)
  );

  phq_cordic #(.IN_W(IN_W), .PH_W(PH_W), .ITER(ITER), .IW(IW)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (step),
    .idx   (idx),
    .mag_x (mag_x),
    .mag_y (mag_y),
    .angle (core_angle)
  );

  always_comb begin
    phase_d = (zero_q ? '0 : core_angle) + {region_q, {(PH_W-2){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= REG_XP_YP;
      zero_q   <= 1'b0;
    end else if (accept) begin
      region_q <= region;
      zero_q   <= both_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (finish) phase_q <= phase_d;
  end

  assign out_phase = phase_q;

  // Latency tracker used only by the checks below.
  logic [LCW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy)   lat_cnt <= lat_cnt + LCW'(1);
  end

  // R3: result appears a fixed number of cycles after the sample is taken
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_cnt == LCW'(LAT - 1)));
  // R10: an all-zero sample reports only a whole number of quarter turns
  assert_zero_angle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zero_q) |-> (out_phase[PH_W-3:0] == '0));
  // R11: strobes during a busy period leave the captured region alone
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> $stable(region_q));

endmodule

// File: tb/phase_quad_est_test.sv
`timescale 1ns/1ps
module phase_quad_est_test;

  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0, in_y = '0;
  logic        busy, out_valid;
  logic [15:0] out_phase;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit prev_ov = 1'b0;

  typedef struct {
    logic [15:0] exp;
    int          due;
    int          tol;
    string       tag;
  } item_t;
  item_t sb[$];

  phase_quad_est uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .busy(busy), .out_valid(out_valid), .out_phase(out_phase)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] model(input int x, input int y);
    int  mx, my, core, off;
    real r;
    mx = (x < 0) ? ((x == -32768) ? 32767 : -x) : x;
    my = (y < 0) ? ((y == -32768) ? 32767 : -y) : y;
    if (x >= 0 && y >= 0)     off = 0;
    else if (x < 0 && y >= 0) off = 16384;
    else if (x < 0)           off = 32768;
    else                      off = 49152;
    if (x == 0 && y == 0) core = 0;
    else begin
      r    = $atan2(real'(my), real'(mx));
      core = int'(r * 65536.0 / (2.0 * PI));
    end
    return 16'(core + off);
  endfunction

  task automatic send(input int x, input int y, input string tag, input int tol);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_x = 16'(x);
    in_y = 16'(y);
    it.exp = model(x, y);
    it.due = cyc + 16;
    it.tol = tol;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    check(busy === 1'b1, "R2 busy after take", busy, 1);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ov) begin
        check(busy === 1'b0, "R2 busy after result", busy, 0);
        check(out_valid === 1'b0, "R3 pulse width", out_valid, 0);
      end
      if (out_valid) begin
        check(busy === 1'b1, "R2 busy with result", busy, 1);
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected result", out_phase, 0);
        end else begin
          item_t it;
          int d;
          it = sb.pop_front();
          d = int'(16'(out_phase - it.exp));
          if (d > 32768) d = 65536 - d;
          check(d <= it.tol, it.tag, out_phase, it.exp);
          check(cyc == it.due, "R3 latency", cyc, it.due);
        end
      end
      prev_ov = out_valid;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(out_phase === 16'h0000, "R1 out_phase", out_phase, 0);

    // R4: first region
    send(20000, 10000, "R4", 8);
    send(10000, 20000, "R4", 8);
    send(30000, 30000, "R4", 8);
    send(25000, 0, "R4", 8);
    send(0, 25000, "R4", 8);
    // R5
    send(-20000, 5000, "R5", 8);
    send(-1000, 30000, "R5", 8);
    send(-25000, 0, "R5", 8);
    // R6
    send(-15000, -15000, "R6", 8);
    send(-30000, -2000, "R6", 8);
    // R7
    send(20000, -5000, "R7", 8);
    send(3000, -30000, "R7", 8);
    // R8: wrap to zero
    send(0, -20000, "R8", 8);
    send(1000, -32000, "R8", 8);
    // R9: most negative code saturates
    send(-32768, 0, "R9", 8);
    send(-32768, -32768, "R9", 8);
    send(5000, -32768, "R9", 8);
    send(32767, -32768, "R9", 8);
    // R10: zero vector exact
    send(0, 0, "R10", 0);

    // R11: strobes while busy are ignored
    send(12000, 7000, "R11 first result kept", 8);
    while (busy) begin
      in_valid = 1'b1;
      in_x = 16'(-1234);
      in_y = 16'(-5678);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (25) @(negedge clk);
    check(sb.size() == 0, "R11 pending results", sb.size(), 0);
    check(out_valid === 1'b0 && busy === 1'b0, "R11 idle after noise", {busy, out_valid}, 0);

    // Back-to-back acceptance after ignore test
    send(-9000, 9000, "R5", 8);
    wait (sb.size() == 0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule